// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences a microcontroller between its run state and three low-power states: Sleep, Stop and Standby. Software selects the target with two request bits, a deep-sleep bit and a power-down bit. The move happens only when the core issues a wait-for-interrupt pulse. In each state the controller drives registered enables for the CPU clock gate, the core-domain clock gate, the PLL, the internal RC oscillator, the external crystal oscillator and core-domain power. It also drives a two-bit regulator mode.

Each low-power state listens only to its own set of wake sources. In Sleep, any enabled interrupt or event resumes execution in place. In Stop, any external-interrupt line resumes execution in place: the general lines, the voltage-detector output, the RTC alarm or a USB wakeup. Before clocks return, the internal oscillator is re-enabled and the controller waits for its ready input. Standby is left only through a reset-like exit: a rising edge on the wake pin, an RTC alarm, a watchdog reset or the external reset pin. This exit raises a system reset pulse of programmable length and sets a sticky standby flag. The controller reports the cause of the last wakeup.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After the synchronous reset, pm_state is 0 (Run). All five clock and oscillator enables are 1, reg_mode is 00 (main), core_pwr_en is 1, sys_rst is 0, standby_flag is 0 and wake_cause is 0. State codes are Run 0, Sleep 1, Stop 2, Stop-wake 3, Standby 4, Standby-exit reset 5.
- R2: In Run, a wfi pulse with req_deep=0 moves to Sleep at that clock edge. In Sleep cpu_clk_en is 0 while every other enable stays 1 and reg_mode stays 00. Without wfi, the request bits change nothing.
- R3: Sleep returns to Run on the edge where irq_any is 1, with wake_cause 1. External lines, the voltage detector, the RTC alarm and the USB wakeup leave Sleep unchanged.
- R4: A wfi pulse with req_deep=1 and req_pdown=0 enters Stop. In Stop both clock gates and the PLL, internal-oscillator and crystal enables are 0, and core_pwr_en stays 1.
- R5: In Stop, reg_mode is 01 (low-power) if req_lpreg was 1 in the wfi cycle, else 00. This value is held for the whole Stop stay.
- R6: Stop is left on the edge where any ext_lines bit, pvd_out, rtc_alarm or usb_wake is 1. The controller enters state 3, with hsi_en 1, clocks still gated, reg_mode 00 and wake_cause 2. irq_any alone does not leave Stop.
- R7: State 3 holds while hsi_ready is 0 and returns to Run on the edge where hsi_ready is 1.
- R8: A wfi pulse with req_deep=1 and req_pdown=1 enters Standby. There reg_mode is 10 (off), core_pwr_en is 0 and every clock and oscillator enable is 0. Ext lines, irq_any, pvd_out, usb_wake and a wake pin held high without a rising edge are ignored.
- R9: Standby is left by ext_rst, iwdg_rst, a rising edge of wkup_pin or rtc_alarm. wake_cause is 6, 5, 3 or 4 respectively. When several arrive together the priority is ext_rst, then iwdg_rst, then the wake pin, then the RTC alarm.
- R10: On Standby exit, sys_rst is 1 for exactly RST_CYCLES cycles, with reg_mode 00, core_pwr_en 1 and the CPU clock gated. The controller then returns to Run.
- R11: standby_flag becomes 1 on the Standby exit edge and stays 1 until an sbf_clr cycle. If the flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi | input | 1 | Wait-for-interrupt pulse from the core |
| req_deep | input | 1 | Deep-sleep request bit |
| req_pdown | input | 1 | Power-down request bit (Standby when deep) |
| req_lpreg | input | 1 | Regulator low-power select for Stop |
| irq_any | input | 1 | Any enabled interrupt or event (Sleep wake) |
| ext_lines | input | NUM_EXT | General external-interrupt lines |
| pvd_out | input | 1 | Voltage-detector line |
| rtc_alarm | input | 1 | RTC alarm |
| usb_wake | input | 1 | USB wakeup line |
| wkup_pin | input | 1 | Wake pin, rising edge used in Standby |
| iwdg_rst | input | 1 | Independent watchdog reset |
| ext_rst | input | 1 | External reset pin, active high |
| hsi_ready | input | 1 | Internal oscillator ready |
| sbf_clr | input | 1 | Software clear of the standby flag |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_clk_en | output | 1 | Core-domain clock gate enable |
| pll_en | output | 1 | PLL enable |
| hsi_en | output | 1 | Internal RC oscillator enable |
| hse_en | output | 1 | External crystal oscillator enable |
| reg_mode | output | 2 | Regulator mode: 00 main, 01 low-power, 10 off |
| core_pwr_en | output | 1 | Core-domain power enable |
| sys_rst | output | 1 | System reset pulse after Standby exit |
| pm_state | output | 3 | Current state code |
| wake_cause | output | 3 | Cause of the last wakeup |
| standby_flag | output | 1 | Sticky Standby-exit flag |

## Verification
Two functions can act in the same cycle: the set of the sticky standby flag on a Standby exit, and its software clear. The bench holds sbf_clr high through a Standby exit caused by the RTC alarm and expects the flag to read 1 afterwards. Several Standby exit sources also coincide, both in a directed case and in randomly chosen subsets. The reported cause must follow the stated priority, computed by a bench function.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PS_RUN       = 3'd0,
    PS_SLEEP     = 3'd1,
    PS_STOP      = 3'd2,
    PS_STOP_WAKE = 3'd3,
    PS_STANDBY   = 3'd4,
    PS_SB_RST    = 3'd5
  } pstate_e;

  localparam logic [1:0] REG_MAIN = 2'b00;
  localparam logic [1:0] REG_LP   = 2'b01;
  localparam logic [1:0] REG_OFF  = 2'b10;

  localparam logic [2:0] WC_NONE  = 3'd0;
  localparam logic [2:0] WC_IRQ   = 3'd1;
  localparam logic [2:0] WC_EXTI  = 3'd2;
  localparam logic [2:0] WC_WKPIN = 3'd3;
  localparam logic [2:0] WC_RTC   = 3'd4;
  localparam logic [2:0] WC_IWDG  = 3'd5;
  localparam logic [2:0] WC_XRST  = 3'd6;

  typedef struct packed {
    logic       cpu;
    logic       core;
    logic       pll;
    logic       hsi;
    logic       hse;
    logic [1:0] regm;
    logic       pwr;
    logic       rst;
  } ctl_t;

endpackage

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wfi,
  input  logic    req_deep,
  input  logic    req_pdown,
  input  logic    req_lpreg,
  input  logic    hsi_ready,
  input  logic    wake_hit,
  output pstate_e st_q,
  output pstate_e st_d,
  output logic    lp_d
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

  logic          lp_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    lp_d  = lp_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PS_RUN: begin
        if (wfi) begin
          if (!req_deep) begin
            st_d = PS_SLEEP;
          end else if (!req_pdown) begin
            st_d = PS_STOP;
            lp_d = req_lpreg;
          end else begin
            st_d = PS_STANDBY;
          end
        end
      end
      PS_SLEEP:     if (wake_hit) st_d = PS_RUN;
      PS_STOP:      if (wake_hit) begin
                      st_d = PS_STOP_WAKE;
                      lp_d = 1'b0;
                    end
      PS_STOP_WAKE: if (hsi_ready) st_d = PS_RUN;
      PS_STANDBY:   if (wake_hit) begin
                      st_d  = PS_SB_RST;
                      cnt_d = CNT_LOAD;
                    end
      PS_SB_RST: begin
        if (cnt_q == '0) st_d = PS_RUN;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_RUN;
      lp_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      lp_q  <= lp_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwrseq_wake.sv
module pwrseq_wake
  import pwrseq_pkg::*;
#(
  parameter int NUM_EXT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  pstate_e            st_q,
  input  logic               irq_any,
  input  logic [NUM_EXT-1:0] ext_lines,
  input  logic               pvd_out,
  input  logic               rtc_alarm,
  input  logic               usb_wake,
  input  logic               wkup_pin,
  input  logic               iwdg_rst,
  input  logic               ext_rst,
  input  logic               sbf_clr,
  output logic               wake_hit,
  output logic [2:0]         wake_cause,
  output logic               standby_flag
);
  localparam int NSTOP = NUM_EXT + 3;

  logic [NSTOP-1:0] stop_vec;
  logic             wk_prev;
  logic             wk_rise;
  logic [2:0]       cause_d;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EXT; gi++) begin : g_ext
      assign stop_vec[gi] = ext_lines[gi];
    end
  endgenerate
  assign stop_vec[NUM_EXT]   = pvd_out;
  assign stop_vec[NUM_EXT+1] = rtc_alarm;
  assign stop_vec[NUM_EXT+2] = usb_wake;

  assign wk_rise = wkup_pin & ~wk_prev;

  always_comb begin
    wake_hit = 1'b0;
    cause_d  = WC_NONE;
    unique case (st_q)
      PS_SLEEP: if (irq_any) begin
        wake_hit = 1'b1;
        cause_d  = WC_IRQ;
      end
      PS_STOP: if (|stop_vec) begin
        wake_hit = 1'b1;
        cause_d  = WC_EXTI;
      end
      PS_STANDBY: begin
        if (ext_rst) begin
          wake_hit = 1'b1;
          cause_d  = WC_XRST;
        end else if (iwdg_rst) begin
          wake_hit = 1'b1;
          cause_d  = WC_IWDG;
        end else if (wk_rise) begin
          wake_hit = 1'b1;
          cause_d  = WC_WKPIN;
        end else if (rtc_alarm) begin
          wake_hit = 1'b1;
          cause_d  = WC_RTC;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_prev      <= 1'b1;
      wake_cause   <= WC_NONE;
      standby_flag <= 1'b0;
    end else begin
      wk_prev <= wkup_pin;
      if (wake_hit) wake_cause <= cause_d;
      if (wake_hit && st_q == PS_STANDBY) standby_flag <= 1'b1;
      else if (sbf_clr)                   standby_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pwrseq_ctl.sv
module pwrseq_ctl
  import pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pstate_e st_d,
  input  logic    lp_d,
  output ctl_t    ctl_q,
  output pstate_e st_out
);
  function automatic ctl_t decode(pstate_e s, logic lp);
    ctl_t c;
    c = '{cpu:1'b1, core:1'b1, pll:1'b1, hsi:1'b1, hse:1'b1,
          regm:REG_MAIN, pwr:1'b1, rst:1'b0};
    unique case (s)
      PS_RUN: ;
      PS_SLEEP: c.cpu = 1'b0;
      PS_STOP: begin
        c = '{cpu:1'b0, core:1'b0, pll:1'b0, hsi:1'b0, hse:1'b0,
              regm:(lp ? REG_LP : REG_MAIN), pwr:1'b1, rst:1'b0};
      end
      PS_STOP_WAKE: begin
        c = '{cpu:1'b0, core:1'b0, pll:1'b0, hsi:1'b1, hse:1'b0,
              regm:REG_MAIN, pwr:1'b1, rst:1'b0};
      end
      PS_STANDBY: begin
        c = '{cpu:1'b0, core:1'b0, pll:1'b0, hsi:1'b0, hse:1'b0,
              regm:REG_OFF, pwr:1'b0, rst:1'b0};
      end
      PS_SB_RST: begin
        c = '{cpu:1'b0, core:1'b1, pll:1'b0, hsi:1'b1, hse:1'b0,
              regm:REG_MAIN, pwr:1'b1, rst:1'b1};
      end
      default: ;
    endcase
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= decode(PS_RUN, 1'b0);
      st_out <= PS_RUN;
    end else begin
      ctl_q  <= decode(st_d, lp_d);
      st_out <= st_d;
    end
  end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NUM_EXT    = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wfi,
  input  logic               req_deep,
  input  logic               req_pdown,
  input  logic               req_lpreg,
  input  logic               irq_any,
  input  logic [NUM_EXT-1:0] ext_lines,
  input  logic               pvd_out,
  input  logic               rtc_alarm,
  input  logic               usb_wake,
  input  logic               wkup_pin,
  input  logic               iwdg_rst,
  input  logic               ext_rst,
  input  logic               hsi_ready,
  input  logic               sbf_clr,
  output logic               cpu_clk_en,
  output logic               core_clk_en,
  output logic               pll_en,
  output logic               hsi_en,
  output logic               hse_en,
  output logic [1:0]         reg_mode,
  output logic               core_pwr_en,
  output logic               sys_rst,
  output logic [2:0]         pm_state,
  output logic [2:0]         wake_cause,
  output logic               standby_flag
);
  pstate_e st_q, st_d, st_out;
  logic    lp_d;
  logic    wake_hit;
  ctl_t    ctl_q;

  pwrseq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .wfi(wfi), .req_deep(req_deep),
    .req_pdown(req_pdown), .req_lpreg(req_lpreg), .hsi_ready(hsi_ready),
    .wake_hit(wake_hit), .st_q(st_q), .st_d(st_d), .lp_d(lp_d)
  );

  pwrseq_wake #(.NUM_EXT(NUM_EXT)) u_wake (
    .clk(clk), .rst(rst), .st_q(st_q), .irq_any(irq_any),
    .ext_lines(ext_lines), .pvd_out(pvd_out), .rtc_alarm(rtc_alarm),
    .usb_wake(usb_wake), .wkup_pin(wkup_pin), .iwdg_rst(iwdg_rst),
    .ext_rst(ext_rst), .sbf_clr(sbf_clr), .wake_hit(wake_hit),
    .wake_cause(wake_cause), .standby_flag(standby_flag)
  );

  pwrseq_ctl u_ctl (
    .clk(clk), .rst(rst), .st_d(st_d), .lp_d(lp_d),
    .ctl_q(ctl_q), .st_out(st_out)
  );

  assign cpu_clk_en  = ctl_q.cpu;
  assign core_clk_en = ctl_q.core;
  assign pll_en      = ctl_q.pll;
  assign hsi_en      = ctl_q.hsi;
  assign hse_en      = ctl_q.hse;
  assign reg_mode    = ctl_q.regm;
  assign core_pwr_en = ctl_q.pwr;
  assign sys_rst     = ctl_q.rst;
  assign pm_state    = st_out;

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wfi,
  input logic       req_deep,
  input logic       req_pdown,
  input logic       req_lpreg,
  input logic       irq_any,
  input logic       ext_rst,
  input logic       hsi_ready,
  input logic       sbf_clr,
  input logic       cpu_clk_en,
  input logic       core_clk_en,
  input logic       pll_en,
  input logic       hsi_en,
  input logic       hse_en,
  input logic [1:0] reg_mode,
  input logic       sys_rst,
  input logic [2:0] pm_state,
  input logic       standby_flag
);
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd0 && wfi && !req_deep) |=> (!cpu_clk_en && core_clk_en));

  a_r4_stop_osc_off: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd2) |-> (!pll_en && !hsi_en && !hse_en && !core_clk_en));

  a_r5_stop_regsel: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd0 && wfi && req_deep && !req_pdown)
      |=> (reg_mode == ($past(req_lpreg) ? 2'b01 : 2'b00)));

  a_r3_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd1 && !irq_any) |=> (pm_state == 3'd1));

  a_r7_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd3 && !hsi_ready) |=> (pm_state == 3'd3));

  a_r9_xrst_exit: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd4 && ext_rst) |=> (sys_rst && standby_flag));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (standby_flag && !sbf_clr) |=> standby_flag);

  a_r8_standby_off: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 3'd4) |-> (reg_mode == 2'b10 && !cpu_clk_en && !hsi_en));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (.*);

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;
  localparam int NE = 16;
  localparam int RC = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, wfi, req_deep, req_pdown, req_lpreg, irq_any;
  logic [NE-1:0] ext_lines;
  logic pvd_out, rtc_alarm, usb_wake, wkup_pin, iwdg_rst, ext_rst;
  logic hsi_ready, sbf_clr;
  logic cpu_clk_en, core_clk_en, pll_en, hsi_en, hse_en, core_pwr_en, sys_rst;
  logic [1:0] reg_mode;
  logic [2:0] pm_state, wake_cause;
  logic standby_flag;

  int n_chk = 0;
  int n_err = 0;

  pwrseq_ctrl #(.NUM_EXT(NE), .RST_CYCLES(RC)) u_pwrseq_ctrl (.*);

  function automatic logic [12:0] expv(int st, bit lp);
    case (st)
      0: return {3'd0, 5'b11111, 2'b00, 1'b1, 1'b0};
      1: return {3'd1, 5'b01111, 2'b00, 1'b1, 1'b0};
      2: return {3'd2, 5'b00000, (lp ? 2'b01 : 2'b00), 1'b1, 1'b0};
      3: return {3'd3, 5'b00010, 2'b00, 1'b1, 1'b0};
      4: return {3'd4, 5'b00000, 2'b10, 1'b0, 1'b0};
      default: return {3'd5, 5'b01010, 2'b00, 1'b1, 1'b1};
    endcase
  endfunction

  function automatic logic [12:0] gotv();
    return {pm_state, cpu_clk_en, core_clk_en, pll_en, hsi_en, hse_en,
            reg_mode, core_pwr_en, sys_rst};
  endfunction

  function automatic logic [2:0] sb_cause(logic [3:0] m);
    if (m[0]) return 3'd6;
    if (m[1]) return 3'd5;
    if (m[2]) return 3'd3;
    return 3'd4;
  endfunction

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic enter(bit deep, bit pdn, bit lp);
    req_deep = deep; req_pdown = pdn; req_lpreg = lp; wfi = 1'b1;
    tick();
    wfi = 1'b0; req_lpreg = ~lp;
  endtask

  task automatic noise_on();
    ext_lines = '1; pvd_out = 1'b1; usb_wake = 1'b1;
  endtask

  task automatic noise_off();
    ext_lines = '0; pvd_out = 1'b0; usb_wake = 1'b0; irq_any = 1'b0;
    rtc_alarm = 1'b0;
  endtask

  task automatic finish_reset(string r);
    int cnt = 1;
    for (int i = 0; i < 100 && sys_rst; i++) begin
      tick();
      if (sys_rst) cnt++;
    end
    chk(r, cnt, RC);
    chk(r, gotv(), expv(0, 0));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; wfi = 0; req_deep = 0; req_pdown = 0; req_lpreg = 0;
    irq_any = 0; ext_lines = '0; pvd_out = 0; rtc_alarm = 0; usb_wake = 0;
    wkup_pin = 0; iwdg_rst = 0; ext_rst = 0; hsi_ready = 0; sbf_clr = 0;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 outputs", gotv(), expv(0, 0));
    chk("R1 flag", standby_flag, 0);
    chk("R1 cause", wake_cause, 0);

    // R2 no wfi, no move
    req_deep = 1; req_pdown = 1;
    repeat (3) tick();
    chk("R2 no wfi", gotv(), expv(0, 0));

    // R2/R3 sleep
    enter(0, 1, 0);
    chk("R2 sleep entry", gotv(), expv(1, 0));
    noise_on(); rtc_alarm = 1;
    repeat (2) tick();
    chk("R3 sleep ignores lines", gotv(), expv(1, 0));
    noise_off(); irq_any = 1;
    tick();
    irq_any = 0;
    chk("R3 sleep wake", gotv(), expv(0, 0));
    chk("R3 cause", wake_cause, 1);

    // R4/R5/R6/R7 stop with low-power regulator
    enter(1, 0, 1);
    chk("R4 R5 stop lp", gotv(), expv(2, 1));
    irq_any = 1;
    repeat (2) tick();
    irq_any = 0;
    chk("R6 irq ignored in stop", gotv(), expv(2, 1));
    ext_lines[5] = 1;
    tick();
    ext_lines = '0;
    chk("R6 stop wake", gotv(), expv(3, 0));
    chk("R6 cause", wake_cause, 2);
    repeat (3) tick();
    chk("R7 wait ready", gotv(), expv(3, 0));
    hsi_ready = 1;
    tick();
    hsi_ready = 0;
    chk("R7 back to run", gotv(), expv(0, 0));

    // R5 stop with main regulator, usb wake
    enter(1, 0, 0);
    chk("R5 stop main", gotv(), expv(2, 0));
    usb_wake = 1;
    tick();
    usb_wake = 0;
    chk("R6 usb wake", gotv(), expv(3, 0));
    hsi_ready = 1; tick(); hsi_ready = 0;

    // R8/R9/R10/R11 standby via wake pin
    wkup_pin = 1;
    tick();
    enter(1, 1, 0);
    chk("R8 standby entry", gotv(), expv(4, 0));
    noise_on(); irq_any = 1;
    repeat (2) tick();
    noise_off();
    chk("R8 standby ignores", gotv(), expv(4, 0));
    wkup_pin = 0; tick();
    wkup_pin = 1; tick();
    wkup_pin = 0;
    chk("R10 exit reset", gotv(), expv(5, 0));
    chk("R9 cause pin", wake_cause, 3);
    chk("R11 flag set", standby_flag, 1);
    finish_reset("R10 pulse length");
    repeat (3) tick();
    chk("R11 sticky", standby_flag, 1);
    sbf_clr = 1; tick(); sbf_clr = 0;
    chk("R11 cleared", standby_flag, 0);

    // R11 set and clear in the same cycle: set wins
    enter(1, 1, 0);
    sbf_clr = 1; rtc_alarm = 1;
    tick();
    rtc_alarm = 0;
    chk("R11 set beats clear", standby_flag, 1);
    chk("R9 cause rtc", wake_cause, 4);
    sbf_clr = 0;
    finish_reset("R10 pulse length rtc");

    // R9 all sources together
    enter(1, 1, 0);
    ext_rst = 1; iwdg_rst = 1; rtc_alarm = 1; wkup_pin = 1;
    tick();
    ext_rst = 0; iwdg_rst = 0; rtc_alarm = 0; wkup_pin = 0;
    chk("R9 priority all", wake_cause, 6);
    finish_reset("R10 pulse length all");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int m = $urandom % 3;
      bit lp = 1'($urandom);
      sbf_clr = 1; tick(); sbf_clr = 0;
      if (m == 0) begin
        enter(0, 1'($urandom), lp);
        chk("R2 rnd sleep", gotv(), expv(1, 0));
        irq_any = 1; tick(); irq_any = 0;
        chk("R3 rnd wake", {gotv(), wake_cause}, {expv(0, 0), 3'd1});
      end else if (m == 1) begin
        int idx = $urandom % (NE + 3);
        int d = $urandom % 5;
        enter(1, 0, lp);
        chk("R5 rnd stop", gotv(), expv(2, lp));
        if (idx < NE) ext_lines[idx] = 1;
        else if (idx == NE) pvd_out = 1;
        else if (idx == NE + 1) rtc_alarm = 1;
        else usb_wake = 1;
        tick();
        noise_off();
        chk("R6 rnd stop wake", {gotv(), wake_cause}, {expv(3, 0), 3'd2});
        repeat (d) tick();
        chk("R7 rnd hold", gotv(), expv(3, 0));
        hsi_ready = 1; tick(); hsi_ready = 0;
        chk("R7 rnd run", gotv(), expv(0, 0));
      end else begin
        logic [3:0] mk = 4'($urandom);
        if (mk == 0) mk = 4'b1000;
        enter(1, 1, lp);
        chk("R8 rnd standby", gotv(), expv(4, 0));
        ext_rst = mk[0]; iwdg_rst = mk[1]; wkup_pin = mk[2]; rtc_alarm = mk[3];
        tick();
        ext_rst = 0; iwdg_rst = 0; wkup_pin = 0; rtc_alarm = 0;
        chk("R9 rnd cause", wake_cause, sb_cause(mk));
        chk("R11 rnd flag", standby_flag, 1);
        finish_reset("R10 rnd pulse");
      end
    end

    summary();
    $finish;
  end
endmodule